// File: doc/BRIEF.md
# Coprocessor Control and Mailbox Register Block

This block is the main-processor side of the register set that controls a secondary processor and exchanges messages with it. The main processor drives a 16-bit bus with two byte-lane strobes. Through it, the main side can reset, halt and release the secondary processor, raise a level-2 interrupt to it, and post bytes into a mailbox. The secondary processor has a separate write port. It fills the return mailbox, writes its own half of a shared flag word, and acknowledges pending interrupt bits.

The register window is 64 bytes and repeats four times across a 256-byte page. Each word has its even byte on data bits 15:8 and its odd byte on data bits 7:0. Main-side reads are combinational from the current address. All writes take effect on the rising clock edge.

Top module: `cop_mbox_regs`

## Requirements
- R1: After reset the control byte, interrupt flag, pending bits, both flag bytes and all mailbox bytes are zero, so every read returns 0. The reset pulse is low, the halt output is high and the interrupt level is 0.
- R2: The register index is taken from address bits 5:0, so addresses that differ only in bits 7:6 reach the same register. In each word the even-offset byte travels on data bits 15:8 under lane strobe bit 1, and the odd-offset byte travels on data bits 7:0 under lane strobe bit 0.
- R3: The control byte sits at offset 0x01, with bit 0 as the run bit and bit 1 as the hold request. A write that sets the run bit while the stored run bit is 0 produces a reset pulse that is high for exactly one cycle, in the cycle after the write edge. Any other control write produces no pulse.
- R4: The halt output is high whenever the stored run bit is 0. It is also high whenever both the run bit and the hold request are 1. It is low only when the run bit is 1 and the hold request is 0.
- R5: The interrupt flag is bit 0 of the byte at offset 0x00, which is bit 8 of a word write. Writing 1 there while interrupt-mask bit 2 is high sets the flag and pending bit 2. Writing 0, or writing 1 while mask bit 2 is low, changes nothing. The flag reads back on word bit 8 at offset 0x00.
- R6: The interrupt level output is the index of the highest bit at or above bit 1 that is both pending and enabled by the mask input. It is 0 when there is no such bit. The level follows the mask input within the same cycle.
- R7: A sub-side acknowledge bit clears the matching pending bit, and acknowledging bit 2 also clears the interrupt flag. When a set and an acknowledge of bit 2 meet in the same cycle, the set wins.
- R8: A main write to offset 0x0E or 0x0F, by byte or by word, updates only the high (main-owned) flag byte. A byte write on lane 1 alone uses data bits 15:8. Every other strobe pattern uses data bits 7:0, so for a word write bits 15:8 are ignored.
- R9: Offsets 0x10 to 0x1F hold the main-to-sub mailbox, written per byte lane by the main side only. Sub-side writes there change nothing.
- R10: Offsets 0x20 to 0x2F hold the sub-to-main mailbox, written per byte lane by the sub port and read by the main side. Main-side writes there change nothing.
- R11: A sub write to offset 0x0E or 0x0F updates only the low flag byte, with the same lane rule as R8. The sub port can never change the high flag byte.
- R12: Offsets 0x02 to 0x0D and 0x30 to 0x3F read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| m_we_i | input | 1 | Main-side write enable |
| m_addr_i | input | 8 | Main-side byte address within the page |
| m_be_i | input | 2 | Main-side lane strobes (bit 1 = even byte, bit 0 = odd byte) |
| m_wdata_i | input | 16 | Main-side write data |
| m_rdata_o | output | 16 | Main-side read data for m_addr_i |
| s_we_i | input | 1 | Sub-side write enable |
| s_addr_i | input | 6 | Sub-side register index |
| s_be_i | input | 2 | Sub-side lane strobes |
| s_wdata_i | input | 16 | Sub-side write data |
| s_irq_ack_i | input | PEND_W | Sub-side pending-bit clear mask |
| irq_mask_i | input | PEND_W | Interrupt enable mask of the secondary processor |
| sub_reset_o | output | 1 | One-cycle reset pulse to the secondary processor |
| sub_halt_o | output | 1 | Halt request to the secondary processor |
| sub_irq_lvl_o | output | $clog2(PEND_W) | Interrupt level to the secondary processor |

## Verification
The bench builds the block with its default parameters: sixteen mailbox bytes in each direction and eight pending and mask bits. With sixteen bytes, both mailbox windows are full, so writes at their first and last offsets and at the neighbouring unmapped offsets can all be compared. With eight mask bits, the mask can be driven with bits set above and below the level-2 bit, so the level encoder is shown to ignore bit 0 and to follow live mask changes. The reference model also covers the write ordering corners: a run-bit rewrite without a pulse, a flag set and acknowledge in the same cycle, and mirrored addresses.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  localparam int IDX_W   = 6;
  localparam int AW      = 8;
  localparam int DW      = 16;
  localparam int CTRL_W  = 0;     // word index of IFL/control
  localparam int FLAG_W  = 7;     // word index of flag word (0x0E)
  localparam int M2S_OFS = 16;    // byte offset 0x10
  localparam int S2M_OFS = 32;    // byte offset 0x20

  // lane 1 alone selects the high data byte, anything else the low one
  function automatic logic [7:0] lane_byte(input logic [1:0] be, input logic [DW-1:0] wd);
    return (be == 2'b10) ? wd[15:8] : wd[7:0];
  endfunction
endpackage

// File: rtl/cmb_bytebank.sv
module cmb_bytebank #(
  parameter int NBYTES = 16,
  parameter int BASE   = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [1:0]        be_i,
  input  logic [15:0]       wdata_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_hit_o,
  output logic [15:0]       rd_word_o
);
  localparam int NWORDS = NBYTES / 2;
  localparam int WBASE  = BASE / 2;

  logic [NBYTES-1:0][7:0] mem_q;
  logic unused_idx;
  assign unused_idx = idx_i[0] ^ rd_idx_i[0];

  for (genvar j = 0; j < NBYTES; j++) begin : g_byte
    localparam int WI   = (BASE + j) / 2;
    localparam int LANE = (j % 2 == 0) ? 1 : 0;
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= '0;
      else if (we_i && idx_i[IDX_W-1:1] == (IDX_W-1)'(WI) && be_i[LANE])
        byte_q <= (LANE == 1) ? wdata_i[15:8] : wdata_i[7:0];
    end
    assign mem_q[j] = byte_q;
  end

  always_comb begin
    rd_hit_o  = 1'b0;
    rd_word_o = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (rd_idx_i[IDX_W-1:1] == (IDX_W-1)'(WBASE + w)) begin
        rd_hit_o  = 1'b1;
        rd_word_o = {mem_q[2*w], mem_q[2*w+1]};
      end
    end
  end

  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q)); // R9
endmodule

// File: rtl/cmb_ctrl.sv
module cmb_ctrl #(
  parameter int PEND_W  = 8,
  parameter int IRQ_BIT = 2,
  localparam int LVL_W  = $clog2(PEND_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  input  logic              ifl_set_i,
  input  logic [PEND_W-1:0] irq_mask_i,
  input  logic [PEND_W-1:0] pend_clr_i,
  output logic [7:0]        ctrl_o,
  output logic              ifl_o,
  output logic              sub_reset_o,
  output logic              sub_halt_o,
  output logic [LVL_W-1:0]  irq_lvl_o
);
  logic [7:0]        ctrl_q;
  logic              pulse_q, ifl_q, set_req;
  logic [PEND_W-1:0] pend_q, pend_d;

  assign set_req = ifl_set_i & irq_mask_i[IRQ_BIT];

  always_comb begin
    pend_d = pend_q & ~pend_clr_i;
    if (set_req) pend_d[IRQ_BIT] = 1'b1;  // set beats ack
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      pulse_q <= 1'b0;
      ifl_q   <= 1'b0;
      pend_q  <= '0;
    end else begin
      pulse_q <= ctrl_we_i & ctrl_wdata_i[0] & ~ctrl_q[0];
      if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
      pend_q <= pend_d;
      if (set_req) ifl_q <= 1'b1;
      else if (pend_clr_i[IRQ_BIT]) ifl_q <= 1'b0;
    end
  end

  // level = highest enabled pending bit from bit 1 upward (mask/pend >> 1)
  always_comb begin
    irq_lvl_o = '0;
    for (int i = 1; i < PEND_W; i++)
      if (pend_q[i] && irq_mask_i[i]) irq_lvl_o = LVL_W'(i);
  end

  assign ctrl_o      = ctrl_q;
  assign ifl_o       = ifl_q;
  assign sub_reset_o = pulse_q;
  assign sub_halt_o  = ~ctrl_q[0] | ctrl_q[1];

  AST_PULSE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_reset_o |-> $rose(ctrl_q[0])); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_reset_o |=> !sub_reset_o); // R3
  AST_IFL_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q[IRQ_BIT]) |-> $past(irq_mask_i[IRQ_BIT])); // R5
  AST_LVL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_lvl_o != '0) |-> (pend_q[irq_lvl_o] && irq_mask_i[irq_lvl_o])); // R6
endmodule

// File: rtl/cop_mbox_regs.sv
module cop_mbox_regs
  import cmb_pkg::*;
#(
  parameter int MBOX_BYTES = 16,
  parameter int PEND_W     = 8,
  parameter int IRQ_BIT    = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       m_we_i,
  input  logic [AW-1:0]              m_addr_i,
  input  logic [1:0]                 m_be_i,
  input  logic [DW-1:0]              m_wdata_i,
  output logic [DW-1:0]              m_rdata_o,
  input  logic                       s_we_i,
  input  logic [IDX_W-1:0]           s_addr_i,
  input  logic [1:0]                 s_be_i,
  input  logic [DW-1:0]              s_wdata_i,
  input  logic [PEND_W-1:0]          s_irq_ack_i,
  input  logic [PEND_W-1:0]          irq_mask_i,
  output logic                       sub_reset_o,
  output logic                       sub_halt_o,
  output logic [$clog2(PEND_W)-1:0]  sub_irq_lvl_o
);
  logic [IDX_W-1:0] m_idx;
  logic [IDX_W-2:0] m_word, s_word;
  logic             ctrl_we, ifl_set, m_flag_we, s_flag_we, ifl;
  logic [7:0]       ctrl, main_flag_q, sub_flag_q;
  logic             m2s_hit, s2m_hit;
  logic [DW-1:0]    m2s_word, s2m_word;
  logic             unused_addr;

  assign m_idx       = m_addr_i[IDX_W-1:0];   // bits 7:6 mirror the window
  assign unused_addr = ^m_addr_i[AW-1:IDX_W];
  assign m_word      = m_idx[IDX_W-1:1];
  assign s_word      = s_addr_i[IDX_W-1:1];

  assign ctrl_we   = m_we_i && m_word == (IDX_W-1)'(CTRL_W) && m_be_i[0];
  assign ifl_set   = m_we_i && m_word == (IDX_W-1)'(CTRL_W) && m_be_i[1] && m_wdata_i[8];
  assign m_flag_we = m_we_i && m_word == (IDX_W-1)'(FLAG_W) && (m_be_i != 2'b00);
  assign s_flag_we = s_we_i && s_word == (IDX_W-1)'(FLAG_W) && (s_be_i != 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_flag_q <= '0;
      sub_flag_q  <= '0;
    end else begin
      if (m_flag_we) main_flag_q <= lane_byte(m_be_i, m_wdata_i);
      if (s_flag_we) sub_flag_q  <= lane_byte(s_be_i, s_wdata_i);
    end
  end

  cmb_ctrl #(.PEND_W(PEND_W), .IRQ_BIT(IRQ_BIT)) u_ctrl (
    .clk_i, .rst_ni,
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(m_wdata_i[7:0]), .ifl_set_i(ifl_set),
    .irq_mask_i, .pend_clr_i(s_irq_ack_i),
    .ctrl_o(ctrl), .ifl_o(ifl),
    .sub_reset_o, .sub_halt_o, .irq_lvl_o(sub_irq_lvl_o)
  );

  cmb_bytebank #(.NBYTES(MBOX_BYTES), .BASE(M2S_OFS), .IDX_W(IDX_W)) u_m2s (
    .clk_i, .rst_ni, .we_i(m_we_i), .idx_i(m_idx), .be_i(m_be_i), .wdata_i(m_wdata_i),
    .rd_idx_i(m_idx), .rd_hit_o(m2s_hit), .rd_word_o(m2s_word)
  );

  cmb_bytebank #(.NBYTES(MBOX_BYTES), .BASE(S2M_OFS), .IDX_W(IDX_W)) u_s2m (
    .clk_i, .rst_ni, .we_i(s_we_i), .idx_i(s_addr_i), .be_i(s_be_i), .wdata_i(s_wdata_i),
    .rd_idx_i(m_idx), .rd_hit_o(s2m_hit), .rd_word_o(s2m_word)
  );

  always_comb begin
    if (m_word == (IDX_W-1)'(CTRL_W))      m_rdata_o = {7'b0, ifl, ctrl};
    else if (m_word == (IDX_W-1)'(FLAG_W)) m_rdata_o = {main_flag_q, sub_flag_q};
    else if (m2s_hit)                      m_rdata_o = m2s_word;
    else if (s2m_hit)                      m_rdata_o = s2m_word;
    else                                   m_rdata_o = '0;
  end

  AST_MAIN_FLAG_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(m_we_i && m_word == (IDX_W-1)'(FLAG_W)) |=> $stable(main_flag_q)); // R11
  AST_SUB_FLAG_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_we_i && s_word == (IDX_W-1)'(FLAG_W)) |=> $stable(sub_flag_q)); // R8
endmodule

// File: tb/cop_mbox_regs_tb_top.sv
module cop_mbox_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_we = 1'b0;
  logic [7:0]  m_addr = '0;
  logic [1:0]  m_be = '0;
  logic [15:0] m_wdata = '0;
  logic [15:0] m_rdata;
  logic        s_we = 1'b0;
  logic [5:0]  s_addr = '0;
  logic [1:0]  s_be = '0;
  logic [15:0] s_wdata = '0;
  logic [7:0]  ack = '0;
  logic [7:0]  mask = '0;
  logic        sub_rst, sub_halt;
  logic [2:0]  lvl;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference state
  logic [7:0] r_ctrl = 0, r_pend = 0, r_mflag = 0, r_sflag = 0;
  logic       r_ifl = 0, r_pulse = 0;
  logic [7:0] r_m2s [16];
  logic [7:0] r_s2m [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  cop_mbox_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .m_we_i(m_we), .m_addr_i(m_addr), .m_be_i(m_be), .m_wdata_i(m_wdata), .m_rdata_o(m_rdata),
    .s_we_i(s_we), .s_addr_i(s_addr), .s_be_i(s_be), .s_wdata_i(s_wdata),
    .s_irq_ack_i(ack), .irq_mask_i(mask),
    .sub_reset_o(sub_rst), .sub_halt_o(sub_halt), .sub_irq_lvl_o(lvl)
  );

  function automatic logic [7:0] pick(input logic [1:0] be, input logic [15:0] d);
    if (be == 2'b10) return d[15:8];
    return d[7:0];
  endfunction

  function automatic logic [15:0] exp_read(input logic [7:0] a);
    int e = int'(a[5:1]) * 2;
    if (e == 0)  return {7'b0, r_ifl, r_ctrl};
    if (e == 14) return {r_mflag, r_sflag};
    if (e >= 16 && e < 32) return {r_m2s[e-16], r_m2s[e-15]};
    if (e >= 32 && e < 48) return {r_s2m[e-32], r_s2m[e-31]};
    return 16'h0;
  endfunction

  function automatic logic [2:0] exp_lvl();
    logic [2:0] l = 0;
    logic [7:0] v = (r_pend & mask) >> 1;
    for (int i = 0; i < 7; i++) if (v[i]) l = 3'(i + 1);
    return l;
  endfunction

  task automatic model_step();
    int e;
    logic setf = 0;
    logic np = 0;
    if (m_we) begin
      e = int'(m_addr[5:1]) * 2;
      if (e == 0) begin
        if (m_be[0]) begin np = m_wdata[0] & ~r_ctrl[0]; r_ctrl = m_wdata[7:0]; end
        if (m_be[1] && m_wdata[8] && mask[2]) setf = 1;
      end
      if (e == 14 && m_be != 0) r_mflag = pick(m_be, m_wdata);
      if (e >= 16 && e < 32) begin
        if (m_be[1]) r_m2s[e-16] = m_wdata[15:8];
        if (m_be[0]) r_m2s[e-15] = m_wdata[7:0];
      end
    end
    if (s_we) begin
      e = int'(s_addr[5:1]) * 2;
      if (e == 14 && s_be != 0) r_sflag = pick(s_be, s_wdata);
      if (e >= 32 && e < 48) begin
        if (s_be[1]) r_s2m[e-32] = s_wdata[15:8];
        if (s_be[0]) r_s2m[e-31] = s_wdata[7:0];
      end
    end
    r_pend = r_pend & ~ack;
    if (setf) begin r_pend[2] = 1; r_ifl = 1; end
    else if (ack[2]) r_ifl = 0;
    r_pulse = np;
  endtask

  task automatic check(input bit ok, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [15:0] er = exp_read(m_addr);
    logic        eh = ~r_ctrl[0] | r_ctrl[1];
    logic [2:0]  el = exp_lvl();
    check(m_rdata === er, "rdata", m_rdata, er);
    check(sub_rst === r_pulse, "reset_pulse", 16'(sub_rst), 16'(r_pulse));
    check(sub_halt === eh, "halt", 16'(sub_halt), 16'(eh));
    check(lvl === el, "irq_level", 16'(lvl), 16'(el));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic mwr(input logic [7:0] a, input logic [1:0] be, input logic [15:0] d);
    m_we = 1; m_addr = a; m_be = be; m_wdata = d;
    tick();
    m_we = 0;
  endtask

  task automatic swr(input logic [5:0] a, input logic [1:0] be, input logic [15:0] d);
    s_we = 1; s_addr = a; s_be = be; s_wdata = d;
    tick();
    s_we = 0;
  endtask

  task automatic mrd(input logic [7:0] a);
    m_we = 0; m_addr = a;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin r_m2s[i] = 0; r_s2m[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state at ports before release
    cur_req = "R1";
    compare();
    rst_n = 1;
    for (int a = 0; a < 64; a += 2) mrd(8'(a));

    // R3 / R4: control byte, run edge and hold request
    cur_req = "R3";
    mwr(8'h01, 2'b01, 16'h0001);           // 0->1: pulse, running
    check(sub_rst === 1'b1, "pulse after run edge", 16'(sub_rst), 16'h1);
    mrd(8'h01);
    check(sub_rst === 1'b0, "pulse lasts one cycle", 16'(sub_rst), 16'h0);
    cur_req = "R4";
    mwr(8'h01, 2'b01, 16'h0003);           // hold request, no new pulse
    check(sub_halt === 1'b1, "hold request halts", 16'(sub_halt), 16'h1);
    cur_req = "R3";
    check(sub_rst === 1'b0, "no pulse when run stays 1", 16'(sub_rst), 16'h0);
    cur_req = "R4";
    mwr(8'h01, 2'b01, 16'h0001);
    check(sub_halt === 1'b0, "release", 16'(sub_halt), 16'h0);
    mwr(8'h00, 2'b11, 16'h0002);           // run 0: held whatever hold bit
    check(sub_halt === 1'b1, "run cleared holds", 16'(sub_halt), 16'h1);
    cur_req = "R3";
    mwr(8'h00, 2'b11, 16'h0001);           // word write re-triggers
    check(sub_rst === 1'b1, "word write pulse", 16'(sub_rst), 16'h1);

    // R5: interrupt flag gated by mask bit 2
    cur_req = "R5";
    mask = 8'h00;
    mwr(8'h00, 2'b10, 16'h0100);
    mrd(8'h00);
    check(m_rdata[8] === 1'b0, "masked flag ignored", m_rdata, 16'h0001);
    mask = 8'h04;
    mwr(8'h00, 2'b10, 16'h0000);           // writing 0 does nothing
    mwr(8'h00, 2'b10, 16'h0100);
    mrd(8'h00);
    check(m_rdata[8] === 1'b1, "flag set", m_rdata, 16'h0101);

    // R6: level follows pending & mask
    cur_req = "R6";
    check(lvl === 3'd2, "level 2", 16'(lvl), 16'h2);
    mask = 8'h00; tick();
    check(lvl === 3'd0, "level masked", 16'(lvl), 16'h0);
    mask = 8'hFB; tick();
    check(lvl === 3'd0, "other mask bits only", 16'(lvl), 16'h0);
    mask = 8'hFF; tick();

    // R7: acknowledge, and set beats ack in the same cycle
    cur_req = "R7";
    m_we = 1; m_addr = 8'h00; m_be = 2'b10; m_wdata = 16'h0100; ack = 8'h04;
    tick();
    m_we = 0; ack = 8'h00;
    check(lvl === 3'd2, "set wins over ack", 16'(lvl), 16'h2);
    ack = 8'h04; tick(); ack = 8'h00;
    mrd(8'h00);
    check(lvl === 3'd0 && m_rdata[8] === 1'b0, "ack clears", 16'(lvl), 16'h0);

    // R8: main flag byte
    cur_req = "R8";
    mwr(8'h0E, 2'b10, 16'hA500);
    mwr(8'h0F, 2'b01, 16'h003C);
    mrd(8'h0E);
    check(m_rdata === 16'h3C00, "byte writes hit high byte", m_rdata, 16'h3C00);
    mwr(8'h0E, 2'b11, 16'h7788);
    check(m_rdata === 16'h8800, "word write uses low data", m_rdata, 16'h8800);

    // R11: sub flag byte
    cur_req = "R11";
    swr(6'h0E, 2'b11, 16'h1122);
    swr(6'h0E, 2'b10, 16'h5A00);
    mrd(8'h0E);
    check(m_rdata === 16'h885A, "sub writes low byte only", m_rdata, 16'h885A);

    // R9: main-to-sub mailbox
    cur_req = "R9";
    for (int i = 0; i < 8; i++) mwr(8'(16 + 2*i), 2'b11, 16'(16'hC100 + i * 16'h0203));
    mwr(8'h13, 2'b01, 16'h00EE);
    mwr(8'h1E, 2'b10, 16'hDD00);
    swr(6'h10, 2'b11, 16'hFFFF);           // ignored
    for (int i = 0; i < 8; i++) mrd(8'(16 + 2*i));
    mrd(8'h10);
    check(m_rdata === 16'hC100, "sub cannot write mailbox", m_rdata, 16'hC100);

    // R10: sub-to-main mailbox
    cur_req = "R10";
    for (int i = 0; i < 8; i++) swr(6'(32 + 2*i), 2'b11, 16'(16'h4080 + i * 16'h1101));
    swr(6'h2F, 2'b01, 16'h0077);
    mwr(8'h24, 2'b11, 16'hFFFF);           // ignored
    for (int i = 0; i < 8; i++) mrd(8'(32 + 2*i));
    mrd(8'h24);
    check(m_rdata === 16'h6282, "main cannot write return mailbox", m_rdata, 16'h6282);

    // R2: mirroring and lane mapping
    cur_req = "R2";
    mwr(8'h92, 2'b10, 16'hAB00);
    mrd(8'h52);
    check(m_rdata[15:8] === 8'hAB, "mirror and even lane", m_rdata, 16'hAB00);
    mrd(8'hD3);

    // R12: unmapped offsets
    cur_req = "R12";
    mwr(8'h04, 2'b11, 16'hFFFF);
    mwr(8'h30, 2'b11, 16'hFFFF);
    mwr(8'h3E, 2'b11, 16'hFFFF);
    mrd(8'h04);
    check(m_rdata === 16'h0, "unmapped reads zero", m_rdata, 16'h0);
    for (int a = 0; a < 64; a += 2) mrd(8'(a));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule